// File: doc/BRIEF.md
# Memory Access Fault Checker with Status Capture

This block sits beside an address translation unit and examines every bus cycle that the processor starts. For each cycle it checks whether the virtual page lies beyond the limit set by the active space descriptor. In mapped spaces it also checks whether the page entry grants the kind of access being attempted. A failing check raises a one-cycle abort request before the access can complete. It also raises an inhibit that keeps the internal registers from being selected until the cycle ends.

Three status words hold what software needs to recover from a fault. The control/status word has the mapping enable, three violation flags, and the mode and space of the failing access. The second word holds the virtual address of the last bus cycle. The third holds the address of the last instruction fetch. Capture freezes on the first fault. Later cycles change none of the captured fields until software clears every flag with a high-byte write. The next bus cycle after that captures again.

Top module: `mmu_fault_status`

## Requirements
- R1: A checked cycle whose virtual page (vaddr[15:10]) is greater than desc_maxpg sets the length flag, status word 0 bit 14, and raises abort.
- R2: In a non-transparent space, a read (acc_write=0) with perm_rd=0 sets the read flag (bit 13), and a write (acc_write=1) with perm_wr=0 sets the write flag (bit 12). Both set abort. Permission bits both 0 make every access fault.
- R3: When desc_transp=1 the permission bits are ignored and only the length check can fault.
- R4: Status word 0 (slot 0) reads {enable[15], length[14], read[13], write[12], zeros[11:5], pc-mode[4:3], fault-in-I-space[2], error-access mode[1:0]}.
- R5: Only bits 15:12 of slot 0 are writable, and only by a write with reg_hi_byte=1. Writes without the high byte change nothing.
- R6: Flags are recorded and abort is raised only when mapping is enabled, cyc_early_end=0 and cyc_ireg=0. While any flag is set, further faults still abort but change no flag.
- R7: Slot 1 loads vaddr at every cyc_start and slot 2 loads vaddr at every ifetch. Both hold while any flag is set.
- R8: The error-access mode and I-space bit load cur_mode and ispace at each cyc_start, and the pc-mode field loads pc_mode at each ifetch. All of them hold while any flag is set.
- R9: Reset clears all state, including the enable. Slots 0 to 2 are the status words. Slot 3 raises reg_nxm and reads as zero.
- R10: abort is high for exactly the one cycle after the faulting cyc_start. reg_inhibit rises with it and stays high until a cycle with cyc_done. While reg_inhibit is high, register reads return zero and register writes are ignored.
- R11: Writing zeros to all three flags re-arms capture, so the next cyc_start loads new address, mode and space values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-cycle strobe: a bus cycle begins |
| cyc_done | input | 1 | Current bus cycle ends; drops the inhibit |
| cyc_early_end | input | 1 | Cycle terminated early; suppresses checking |
| cyc_ireg | input | 1 | Cycle targets an internal register; suppresses checking |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| vaddr | input | 16 | Virtual address of the cycle |
| desc_maxpg | input | 6 | Highest legal page of the active space |
| desc_transp | input | 1 | Active space is transparent |
| perm_rd | input | 1 | Page entry grants read |
| perm_wr | input | 1 | Page entry grants write |
| cur_mode | input | 2 | Mode of the current access |
| pc_mode | input | 2 | Mode of the executing instruction |
| ispace | input | 1 | Access is to instruction space |
| ifetch | input | 1 | Instruction or trap-vector fetch strobe |
| reg_sel | input | 1 | Status register access this cycle |
| reg_slot | input | 2 | Status word slot |
| reg_wr | input | 1 | Register write |
| reg_hi_byte | input | 1 | High byte written |
| reg_wdata | input | 16 | Register write data |
| abort | output | 1 | Abort request pulse |
| reg_inhibit | output | 1 | Internal register selection blocked |
| reg_rdata | output | 16 | Register read data |
| reg_nxm | output | 1 | Selected slot does not exist |

## Verification
On every cycle, the embedded properties check four things. Captured words and fields stay still while a flag is set. A transparent cycle never raises a permission flag. Flags do not move while mapping is off, or under a write that lacks the high byte. Abort always comes with the inhibit, and reads under the inhibit return zero. The bench sweeps every page against several limits, with every mix of transparency, direction and permissions, and compares the whole status word. Directed scenarios cover behaviour that only shows over several cycles: the first fault wins over later ones, clearing the flags re-arms capture, and the inhibit blocks register access until the cycle ends.

// File: rtl/mmu_fault_status.sv
module mmu_fault_status #(
  parameter int VA_W   = 16,
  parameter int PG_W   = 6,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              cyc_done,
  input  logic              cyc_early_end,
  input  logic              cyc_ireg,
  input  logic              acc_write,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [PG_W-1:0]   desc_maxpg,
  input  logic              desc_transp,
  input  logic              perm_rd,
  input  logic              perm_wr,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] pc_mode,
  input  logic              ispace,
  input  logic              ifetch,
  input  logic              reg_sel,
  input  logic [1:0]        reg_slot,
  input  logic              reg_wr,
  input  logic              reg_hi_byte,
  input  logic [VA_W-1:0]   reg_wdata,
  output logic              abort,
  output logic              reg_inhibit,
  output logic [VA_W-1:0]   reg_rdata,
  output logic              reg_nxm
);
  localparam int CTL_W = 4;
  localparam int LOW_W = 2 * MODE_W + 1;
  localparam int PAD_W = VA_W - CTL_W - LOW_W;

  logic              map_en, f_len, f_rd, f_wr;
  logic              abort_q, inh_q, isp_q;
  logic [MODE_W-1:0] pcm_q, errm_q;
  logic [VA_W-1:0]   va_q, ia_q;

  wire [PG_W-1:0] vpage = vaddr[VA_W-1 -: PG_W];
  wire any_flag = f_len | f_rd | f_wr;
  wire len_bad  = vpage > desc_maxpg;
  wire rd_bad   = !desc_transp && !acc_write && !perm_rd;
  wire wr_bad   = !desc_transp &&  acc_write && !perm_wr;
  wire checked  = cyc_start && map_en && !cyc_early_end && !cyc_ireg;
  wire hit      = checked && (len_bad || rd_bad || wr_bad);
  wire sel_ok   = reg_sel && !inh_q;
  wire sr0_wr   = sel_ok && reg_wr && reg_hi_byte && (reg_slot == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_en <= 1'b0; f_len <= 1'b0; f_rd <= 1'b0; f_wr <= 1'b0;
      abort_q <= 1'b0; inh_q <= 1'b0; isp_q <= 1'b0;
      pcm_q <= '0; errm_q <= '0; va_q <= '0; ia_q <= '0;
    end else begin
      abort_q <= hit;
      if (hit)           inh_q <= 1'b1;
      else if (cyc_done) inh_q <= 1'b0;
      if (sr0_wr)
        {map_en, f_len, f_rd, f_wr} <= reg_wdata[VA_W-1 -: CTL_W];
      else if (hit && !any_flag) begin
        f_len <= len_bad;
        f_rd  <= rd_bad;
        f_wr  <= wr_bad;
      end
      if (cyc_start && !any_flag) begin
        va_q   <= vaddr;
        errm_q <= cur_mode;
        isp_q  <= ispace;
      end
      if (ifetch && !any_flag) begin
        ia_q  <= vaddr;
        pcm_q <= pc_mode;
      end
    end
  end

  assign abort       = abort_q;
  assign reg_inhibit = inh_q;
  assign reg_nxm     = reg_sel && (reg_slot == 2'd3);

  always_comb begin
    reg_rdata = '0;
    if (sel_ok) begin
      case (reg_slot)
        2'd0:    reg_rdata = {map_en, f_len, f_rd, f_wr, {PAD_W{1'b0}}, pcm_q, isp_q, errm_q};
        2'd1:    reg_rdata = va_q;
        2'd2:    reg_rdata = ia_q;
        default: reg_rdata = '0;
      endcase
    end
  end

  AST_SR1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(any_flag) |-> $stable(va_q) && $stable(errm_q) && $stable(isp_q)); // R7
  AST_SR2_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(any_flag) |-> $stable(ia_q) && $stable(pcm_q)); // R8
  AST_TRANSP_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cyc_start && desc_transp && !sr0_wr) |-> !$rose(f_rd) && !$rose(f_wr)); // R3
  AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(map_en) && !$past(sr0_wr) |-> $stable({f_len, f_rd, f_wr})); // R6
  AST_LOW_BYTE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_sel && reg_wr && !reg_hi_byte && !cyc_start) |-> $stable({map_en, f_len, f_rd, f_wr})); // R5
  AST_ABORT_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> reg_inhibit && $past(cyc_start)); // R10
  AST_INHIBIT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_inhibit |-> reg_rdata == '0); // R10
endmodule

// File: tb/test_mmu_fault_status.sv
module test_mmu_fault_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_start = 0, cyc_done = 0, cyc_early_end = 0, cyc_ireg = 0, acc_write = 0;
  logic [15:0] vaddr = '0;
  logic [5:0]  desc_maxpg = '0;
  logic desc_transp = 0, perm_rd = 0, perm_wr = 0, ispace = 0, ifetch = 0;
  logic [1:0] cur_mode = '0, pc_mode = '0, reg_slot = '0;
  logic reg_sel = 0, reg_wr = 0, reg_hi_byte = 0;
  logic [15:0] reg_wdata = '0;
  logic abort, reg_inhibit, reg_nxm;
  logic [15:0] reg_rdata;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  mmu_fault_status i_mmu_fault_status (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [15:0] d, input logic hi);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_slot = s; reg_wdata = d; reg_hi_byte = hi;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; reg_hi_byte = 0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [15:0] d, output logic n);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_slot = s;
    #1; d = reg_rdata; n = reg_nxm;
    @(negedge clk);
    reg_sel = 0;
  endtask

  task automatic bus(input logic [15:0] va, input logic wr, input logic [5:0] mx,
                     input logic tr, input logic rd, input logic wo, input logic early,
                     input logic ireg, input logic ifx, input logic [1:0] cm,
                     input logic [1:0] pm, input logic isp, input logic dn,
                     output logic ab, output logic ab2);
    @(negedge clk);
    vaddr = va; acc_write = wr; desc_maxpg = mx; desc_transp = tr; perm_rd = rd;
    perm_wr = wo; cyc_early_end = early; cyc_ireg = ireg; ifetch = ifx;
    cur_mode = cm; pc_mode = pm; ispace = isp; cyc_start = 1;
    @(negedge clk);
    cyc_start = 0; ifetch = 0; ab = abort; cyc_done = dn;
    @(negedge clk);
    ab2 = abort; cyc_done = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic n, ab, ab2;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd_reg(0, d, n); check("R9 reset slot0", d, 16'h0000);
    rd_reg(1, d, n); check("R9 reset slot1", d, 16'h0000);
    rd_reg(2, d, n); check("R9 reset slot2", d, 16'h0000);
    check("R9 reset abort", abort, 1'b0);

    bus(16'hFC00, 0, 6'd0, 0, 1, 1, 0, 0, 0, 2'd1, 2'd0, 1'b1, 1, ab, ab2);
    check("R6 disabled no abort", ab, 1'b0);
    rd_reg(0, d, n); check("R6 disabled no flags", d, 16'h0005);
    rd_reg(1, d, n); check("R7 slot1 loads every cycle", d, 16'hFC00);

    wr_reg(0, 16'h8000, 1);
    wr_reg(0, 16'hF000, 0);
    rd_reg(0, d, n); check("R5 low-byte write ignored", d[15:12], 4'h8);

    bus(16'hFC00, 0, 6'd0, 0, 1, 1, 1, 0, 0, 2'd0, 2'd0, 1'b0, 1, ab, ab2);
    check("R6 early end no abort", ab, 1'b0);
    bus(16'hFC00, 0, 6'd0, 0, 1, 1, 0, 1, 0, 2'd0, 2'd0, 1'b0, 1, ab, ab2);
    check("R6 internal reg no abort", ab, 1'b0);
    rd_reg(0, d, n); check("R6 no flags after suppressed", d[15:12], 4'h8);

    bus(16'h0C05, 0, 6'd2, 0, 1, 1, 0, 0, 1, 2'd1, 2'd2, 1'b1, 1, ab, ab2);
    check("R1 length abort", ab, 1'b1);
    check("R10 abort one cycle", ab2, 1'b0);
    bus(16'h0401, 1, 6'd63, 0, 1, 0, 0, 0, 1, 2'd3, 2'd0, 1'b0, 1, ab, ab2);
    check("R6 pending fault still aborts", ab, 1'b1);
    rd_reg(0, d, n); check("R8 first fault frozen", d, 16'hC015);
    rd_reg(1, d, n); check("R7 slot1 frozen", d, 16'h0C05);
    rd_reg(2, d, n); check("R7 slot2 frozen", d, 16'h0C05);

    wr_reg(0, 16'h8000, 1);
    rd_reg(0, d, n); check("R11 flags cleared", d, 16'h8015);
    bus(16'h1234, 0, 6'd63, 0, 1, 1, 0, 0, 0, 2'd2, 2'd0, 1'b0, 1, ab, ab2);
    rd_reg(0, d, n); check("R11 rearmed modes", d, 16'h8012);
    rd_reg(1, d, n); check("R11 rearmed slot1", d, 16'h1234);
    rd_reg(2, d, n); check("R7 slot2 only on fetch", d, 16'h0C05);

    bus(16'h2000, 0, 6'd63, 0, 0, 1, 0, 0, 0, 2'd0, 2'd0, 1'b0, 0, ab, ab2);
    check("R2 read fault abort", ab, 1'b1);
    check("R10 inhibit held", reg_inhibit, 1'b1);
    rd_reg(0, d, n); check("R10 inhibited read zero", d, 16'h0000);
    wr_reg(0, 16'h0000, 1);
    @(negedge clk); cyc_done = 1; @(negedge clk); cyc_done = 0;
    check("R10 inhibit dropped", reg_inhibit, 1'b0);
    rd_reg(0, d, n); check("R10 inhibited write ignored", d, 16'hA010);

    rd_reg(3, d, n); check("R9 slot3 nxm", n, 1'b1); check("R9 slot3 zero", d, 16'h0000);
    rd_reg(0, d, n); check("R9 slot0 exists", n, 1'b0);

    for (int k = 0; k < 4; k++) begin
      for (int pg = 0; pg < 64; pg++) begin
        for (int t = 0; t < 16; t++) begin
          logic [5:0] mx = 6'(k * 21);
          logic tr = t[3], w = t[2], rp = t[1], wp = t[0];
          logic [1:0] cm = 2'((pg + t) % 4);
          logic [1:0] pm = ~cm;
          logic isp = pg[0];
          logic [15:0] va = {6'(pg), 10'((pg * 37 + t * 5) % 1024)};
          logic el = pg > int'(mx);
          logic er = !tr && !w && !rp;
          logic ew = !tr && w && !wp;
          wr_reg(0, 16'h8000, 1);
          bus(va, w, mx, tr, rp, wp, 0, 0, 1, cm, pm, isp, 1, ab, ab2);
          check("R1 R2 R3 sweep abort", ab, el | er | ew);
          rd_reg(0, d, n);
          check("R4 sweep status word", d, {1'b1, el, er, ew, 7'b0, pm, isp, cm});
          rd_reg(2, d, n);
          check("R7 sweep slot2", d, va);
        end
      end
    end
    finish_run();
  end
endmodule